// File: doc/BRIEF.md
# Receiver Lock Indicator and Error Concealment

This block sits between a biphase-mark demodulator and the audio output formatter of a digital audio receiver. It watches two things: whether the preamble of each frame was found, and whether the parity check passed for each subframe. From these it decides when the link is locked. It also raises an error flag that stays up for a fixed number of frames after the data turns clean. The flag is counted in frames rather than clock cycles, so its hold time in milliseconds gets shorter as the sample rate rises.

The block also patches damaged samples before they leave the receiver. A short run of parity failures repeats the last good sample of the same channel. A longer run, or loss of lock, mutes the output to zero. When lock drops, the block sends a one-cycle clear request to the channel-status collector.

Three inputs force the unlocked state: a run enable held low, a stop request, and analog-source mode. While any of them is active, the link counts as unlocked and the error flag is raised.

Top module: `rx_lock_conceal`

## Requirements
- R1: `lock_o` rises at the clock edge that samples the `LOCK_FRAMES`-th consecutive `frame_i` strobe carrying `pre_ok_i`=1. A strobe with `pre_ok_i`=0 while unlocked restarts the count.
- R2: While locked, `lock_o` falls at the edge that samples the `UNLOCK_FRAMES`-th consecutive strobe with `pre_ok_i`=0. A good preamble in between restarts this count, and after the drop both counts start again from zero.
- R3: Any of `run_i`=0, `stop_i`=1 or `analog_i`=1 forces `lock_o`=0 and `error_o`=1 one cycle later, and keeps them there while it lasts.
- R4: `error_o` is 1 while unlocked and is set again by any subframe with `par_ok_i`=0. It returns to 0 only after `HOLD_FRAMES` frame strobes have passed with lock held and no parity failure.
- R5: Each `sub_i` strobe gives a `sample_vld_o` pulse one cycle later. A subframe that passes parity while locked is output unchanged.
- R6: Failed subframes 1 to `CONCEAL_MAX` of a consecutive run output the last good sample of their own channel (`chan_i`=0 left, 1 right). Each channel keeps its own register.
- R7: From failure `CONCEAL_MAX`+1 of a run onward, the output is zero. The first subframe that passes parity ends the run.
- R8: While unlocked or forced, every subframe outputs zero and both last-good registers are cleared, so a failure right after relock outputs zero.
- R9: `cs_clr_o` pulses for exactly one cycle, in the cycle where `lock_o` falls, whatever the cause.
- R10: After reset, `lock_o`=0, `error_o`=1, `sample_o`=0, `sample_vld_o`=0 and `cs_clr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | System run enable; low holds the unlocked state |
| stop_i | input | 1 | Stop request; high forces unlock |
| analog_i | input | 1 | Analog-source mode; high forces unlock |
| frame_i | input | 1 | One-cycle strobe per frame |
| pre_ok_i | input | 1 | Preamble found for this frame, valid with `frame_i` |
| sub_i | input | 1 | One-cycle strobe per subframe |
| chan_i | input | 1 | Subframe channel: 0 left, 1 right |
| par_ok_i | input | 1 | Parity passed, valid with `sub_i` |
| sample_i | input | SAMPLE_W | Demodulated sample, valid with `sub_i` |
| lock_o | output | 1 | Lock indicator |
| error_o | output | 1 | Stretched error flag |
| sample_o | output | SAMPLE_W | Concealed sample |
| sample_vld_o | output | 1 | `sample_o` valid strobe |
| cs_clr_o | output | 1 | Channel-status clear request |

## Verification
The bench builds the block with `SAMPLE_W`=16 and `HOLD_FRAMES`=6. This brings the end of the error hold within a handful of frames, so the exact strobe on which `error_o` falls can be checked. `CONCEAL_MAX` and both lock thresholds keep their defaults. This means the full repeat-then-mute sequence runs through the real limits of 8 repeats and 2 frames, with alternating channels showing that the two last-good registers stay separate.

// File: rtl/rxlc_pkg.sv
package rxlc_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/rxlc_lock_qual.sv
module rxlc_lock_qual #(
  parameter int unsigned LOCK_FRAMES   = 2,
  parameter int unsigned UNLOCK_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic frame_i,
  input  logic pre_ok_i,
  output logic lock_o,
  output logic fall_o
);
  localparam int unsigned GW = $clog2(LOCK_FRAMES + 1);
  localparam int unsigned BW = $clog2(UNLOCK_FRAMES + 1);

  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] bad_q, bad_d;
  logic          lock_q, lock_d, fall_q;

  always_comb begin
    good_d = good_q;
    bad_d  = bad_q;
    lock_d = lock_q;
    if (force_i) begin
      good_d = '0;
      bad_d  = '0;
      lock_d = 1'b0;
    end else if (frame_i) begin
      if (pre_ok_i) begin
        bad_d = '0;
        if (!lock_q) begin
          if (good_q == GW'(LOCK_FRAMES - 1)) begin
            lock_d = 1'b1;
            good_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end else begin
        good_d = '0;
        if (lock_q) begin
          if (bad_q == BW'(UNLOCK_FRAMES - 1)) begin
            lock_d = 1'b0;
            bad_d  = '0;
          end else begin
            bad_d = bad_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      bad_q  <= '0;
      lock_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      good_q <= good_d;
      bad_q  <= bad_d;
      lock_q <= lock_d;
      fall_q <= lock_q & ~lock_d;
    end
  end

  assign lock_o = lock_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/rxlc_err_stretch.sv
module rxlc_err_stretch #(
  parameter int unsigned HOLD_FRAMES = 12288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic lock_i,
  input  logic frame_i,
  input  logic bad_i,
  output logic error_o
);
  localparam int unsigned CW = $clog2(HOLD_FRAMES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(HOLD_FRAMES);
    end else if (force_i || !lock_i || bad_i) begin
      cnt_q <= CW'(HOLD_FRAMES);
    end else if (frame_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign error_o = (cnt_q != '0);
endmodule

// File: rtl/rxlc_conceal.sv
module rxlc_conceal
  import rxlc_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned CONCEAL_MAX = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mute_i,
  input  logic                sub_i,
  input  logic                chan_i,
  input  logic                par_ok_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                vld_o
);
  localparam int unsigned RW = $clog2(CONCEAL_MAX + 2);

  logic [RW-1:0]       run_q;
  logic [SAMPLE_W-1:0] last_q [NUM_CH];
  logic [SAMPLE_W-1:0] out_q;
  logic                vld_q;

  // per-channel last-good registers
  for (genvar c = 0; c < NUM_CH; c++) begin : g_last
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            last_q[c] <= '0;
      else if (mute_i)                                        last_q[c] <= '0;
      else if (sub_i && par_ok_i && chan_i == 1'(c))          last_q[c] <= sample_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= sub_i;
      if (mute_i) begin
        run_q <= '0;
        if (sub_i) out_q <= '0;
      end else if (sub_i) begin
        if (par_ok_i) begin
          run_q <= '0;
          out_q <= sample_i;
        end else if (run_q < RW'(CONCEAL_MAX)) begin
          run_q <= run_q + 1'b1;
          out_q <= last_q[chan_i];
        end else begin
          run_q <= RW'(CONCEAL_MAX + 1);
          out_q <= '0;
        end
      end
    end
  end

  assign sample_o = out_q;
  assign vld_o    = vld_q;
endmodule

// File: rtl/rx_lock_conceal.sv
module rx_lock_conceal #(
  parameter int unsigned SAMPLE_W      = 24,
  parameter int unsigned LOCK_FRAMES   = 2,
  parameter int unsigned UNLOCK_FRAMES = 2,
  parameter int unsigned HOLD_FRAMES   = 12288,
  parameter int unsigned CONCEAL_MAX   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                stop_i,
  input  logic                analog_i,
  input  logic                frame_i,
  input  logic                pre_ok_i,
  input  logic                sub_i,
  input  logic                chan_i,
  input  logic                par_ok_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                lock_o,
  output logic                error_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic                cs_clr_o
);
  logic force_s;
  logic lock_s;

  assign force_s = ~run_i | stop_i | analog_i;

  rxlc_lock_qual #(
    .LOCK_FRAMES  (LOCK_FRAMES),
    .UNLOCK_FRAMES(UNLOCK_FRAMES)
  ) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (force_s),
    .frame_i (frame_i),
    .pre_ok_i(pre_ok_i),
    .lock_o  (lock_s),
    .fall_o  (cs_clr_o)
  );

  rxlc_err_stretch #(
    .HOLD_FRAMES(HOLD_FRAMES)
  ) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .force_i(force_s),
    .lock_i (lock_s),
    .frame_i(frame_i),
    .bad_i  (sub_i & ~par_ok_i),
    .error_o(error_o)
  );

  rxlc_conceal #(
    .SAMPLE_W   (SAMPLE_W),
    .CONCEAL_MAX(CONCEAL_MAX)
  ) u_conceal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mute_i  (force_s | ~lock_s),
    .sub_i   (sub_i),
    .chan_i  (chan_i),
    .par_ok_i(par_ok_i),
    .sample_i(sample_i),
    .sample_o(sample_o),
    .vld_o   (sample_vld_o)
  );

  assign lock_o = lock_s;
endmodule

// File: rtl/rxlc_checker.sv
module rxlc_checker #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                run_i,
  input logic                stop_i,
  input logic                analog_i,
  input logic                sub_i,
  input logic                par_ok_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                lock_o,
  input logic                error_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                sample_vld_o,
  input logic                cs_clr_o
);
  logic forced;
  assign forced = ~run_i | stop_i | analog_i;

  assert_force_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced |=> (!lock_o && error_o));

  assert_unlock_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |=> error_o);

  assert_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && par_ok_i && lock_o && !forced) |=> (sample_o == $past(sample_i)));

  assert_vld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |=> sample_vld_o);

  assert_mute_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && (!lock_o || forced)) |=> (sample_o == '0));

  assert_clr_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_clr_o |-> (!lock_o && $past(lock_o)));

  assert_clr_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_clr_o |=> !cs_clr_o);
endmodule

bind rx_lock_conceal rxlc_checker #(.SAMPLE_W(SAMPLE_W)) u_rxlc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .stop_i      (stop_i),
  .analog_i    (analog_i),
  .sub_i       (sub_i),
  .par_ok_i    (par_ok_i),
  .sample_i    (sample_i),
  .lock_o      (lock_o),
  .error_o     (error_o),
  .sample_o    (sample_o),
  .sample_vld_o(sample_vld_o),
  .cs_clr_o    (cs_clr_o)
);

// File: tb/rx_lock_conceal_tb_top.sv
module rx_lock_conceal_tb_top;
  localparam int unsigned W    = 16;
  localparam int unsigned HOLD = 6;
  localparam int unsigned CMAX = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run_i = 1'b0, stop_i = 1'b0, analog_i = 1'b0;
  logic         frame_i = 1'b0, pre_ok_i = 1'b0;
  logic         sub_i = 1'b0, chan_i = 1'b0, par_ok_i = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic         lock_o, error_o, sample_vld_o, cs_clr_o;
  logic [W-1:0] sample_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [W-1:0] SA = 16'h1234;
  localparam logic [W-1:0] SB = 16'h5678;
  localparam logic [W-1:0] SJ = 16'hDEAD;

  always #5 clk_i = ~clk_i;

  rx_lock_conceal #(
    .SAMPLE_W(W), .LOCK_FRAMES(2), .UNLOCK_FRAMES(2),
    .HOLD_FRAMES(HOLD), .CONCEAL_MAX(CMAX)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .stop_i(stop_i),
    .analog_i(analog_i), .frame_i(frame_i), .pre_ok_i(pre_ok_i),
    .sub_i(sub_i), .chan_i(chan_i), .par_ok_i(par_ok_i), .sample_i(sample_i),
    .lock_o(lock_o), .error_o(error_o), .sample_o(sample_o),
    .sample_vld_o(sample_vld_o), .cs_clr_o(cs_clr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic frame(input logic pre);
    @(negedge clk_i);
    frame_i = 1'b1; pre_ok_i = pre;
    @(negedge clk_i);
    frame_i = 1'b0; pre_ok_i = 1'b0;
  endtask

  task automatic sub(input logic ch, input logic ok, input logic [W-1:0] d,
                     input logic [W-1:0] exp, input string req);
    @(negedge clk_i);
    sub_i = 1'b1; chan_i = ch; par_ok_i = ok; sample_i = d;
    @(negedge clk_i);
    sub_i = 1'b0; par_ok_i = 1'b0;
    chk({req, " sample"}, 32'(sample_o), 32'(exp));
    chk({req, " vld"}, 32'(sample_vld_o), 32'd1);
  endtask

  task automatic t_reset();
    chk("R10 lock", 32'(lock_o), 0);
    chk("R10 error", 32'(error_o), 1);
    chk("R10 sample", 32'(sample_o), 0);
    chk("R10 vld", 32'(sample_vld_o), 0);
    chk("R10 clr", 32'(cs_clr_o), 0);
  endtask

  task automatic t_lock();
    frame(1'b1);
    chk("R1 one good", 32'(lock_o), 0);
    frame(1'b0);
    frame(1'b1);
    chk("R1 restart", 32'(lock_o), 0);
    frame(1'b1);
    chk("R1 locked", 32'(lock_o), 1);
    chk("R4 error at lock", 32'(error_o), 1);
  endtask

  task automatic t_hold();
    for (int i = 0; i < int'(HOLD) - 1; i++) begin
      frame(1'b1);
      chk("R4 hold", 32'(error_o), 1);
    end
    frame(1'b1);
    chk("R4 release", 32'(error_o), 0);
  endtask

  task automatic t_conceal();
    sub(1'b0, 1'b1, SA, SA, "R5 left pass");
    sub(1'b1, 1'b1, SB, SB, "R5 right pass");
    chk("R4 clean", 32'(error_o), 0);
    for (int i = 0; i < int'(CMAX); i++) begin
      sub(1'(i % 2), 1'b0, SJ, (i % 2) ? SB : SA, "R6 repeat");
      chk("R4 parity err", 32'(error_o), 1);
    end
    sub(1'b0, 1'b0, SJ, '0, "R7 mute 9th");
    sub(1'b1, 1'b0, SJ, '0, "R7 mute 10th");
    sub(1'b0, 1'b1, 16'h0F0F, 16'h0F0F, "R7 good ends run");
    sub(1'b1, 1'b0, SJ, SB, "R6 right kept");
    sub(1'b0, 1'b0, SJ, 16'h0F0F, "R6 left updated");
  endtask

  task automatic t_unlock();
    frame(1'b0);
    chk("R2 one miss", 32'(lock_o), 1);
    frame(1'b1);
    frame(1'b0);
    chk("R2 miss restart", 32'(lock_o), 1);
    frame(1'b0);
    chk("R2 lost", 32'(lock_o), 0);
    chk("R9 clr pulse", 32'(cs_clr_o), 1);
    @(negedge clk_i);
    chk("R9 clr one cycle", 32'(cs_clr_o), 0);
    chk("R4 unlocked", 32'(error_o), 1);
    sub(1'b0, 1'b1, SA, '0, "R8 unlocked mute");
    frame(1'b1);
    frame(1'b1);
    chk("R2 relock", 32'(lock_o), 1);
    sub(1'b0, 1'b0, SJ, '0, "R8 last cleared");
  endtask

  task automatic t_force(input int which);
    if (!lock_o) begin frame(1'b1); frame(1'b1); end
    chk("R3 pre", 32'(lock_o), 1);
    @(negedge clk_i);
    case (which)
      0: run_i = 1'b0;
      1: stop_i = 1'b1;
      default: analog_i = 1'b1;
    endcase
    @(negedge clk_i);
    chk("R3 lock", 32'(lock_o), 0);
    chk("R3 error", 32'(error_o), 1);
    chk("R9 forced clr", 32'(cs_clr_o), 1);
    frame(1'b1);
    frame(1'b1);
    chk("R3 held", 32'(lock_o), 0);
    sub(1'b0, 1'b1, SA, '0, "R8 forced mute");
    run_i = 1'b1; stop_i = 1'b0; analog_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_i = 1'b1;
    t_lock();
    t_hold();
    t_conceal();
    t_unlock();
    t_force(0);
    t_force(1);
    t_force(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule